// File: doc/BRIEF.md
# I2C Slave Address Filter

This block sits behind an I2C slave's input synchronizers. It watches the two bus lines for START, repeated START and STOP conditions. It shifts in each byte on SCL rising edges, most significant bit first. It compares the 7-bit address at the top of the first byte of every transaction against a device identifier that software can change at any time. The compare result appears as a read-only flag in bit 0 of the identifier register.

A receive-available interrupt is always raised for the address byte, so that software can inspect the flag. After that, data bytes produce interrupts and update the received-byte output only when the address matched. A transaction addressed to another device stays silent until the next START or repeated START. The interrupt is a level that stays high until software clears it with a strobe.

Top module: `i2c_addr_filter`

## Requirements
- R1: After reset, `id_reg_o` reads 0x42 (device identifier 0x21 in bits 7:1, flag bit 0 = 0) and `irq_o` is 0.
- R2: A write with `reg_wr_en` high loads `reg_wr_data[7:1]` as the identifier. `reg_wr_data[0]` is ignored, and `id_reg_o[0]` always shows the mismatch flag.
- R3: A newly written identifier is used for the next address comparison, and the old identifier no longer matches.
- R4: On the 8th SCL rising edge of the first byte after a START, the flag becomes 0 if byte bits 7:1 equal the identifier and 1 otherwise, visible within 2 clock cycles. The flag holds its value until the next address byte completes, including across STOP.
- R5: With `irq_en` high, `irq_o` rises after every address byte, whether it matched or not, and `rx_data_o` shows the address byte.
- R6: After a matching address, every data byte raises `irq_o` (when enabled) and appears on `rx_data_o`.
- R7: After a non-matching address, data bytes raise no interrupt and leave `rx_data_o` unchanged until the next START.
- R8: A repeated START (SDA falling while SCL high, with no STOP before it) re-arms address capture, so the next byte is compared as an address.
- R9: The 8th bit of the address byte (the read/write bit) is excluded from the compare.
- R10: `irq_o` is a level that holds until an `irq_clr` strobe clears it. With `irq_en` low, no byte raises it.
- R11: The 9th (acknowledge) SCL clock of each byte is not shifted into the received data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| reg_wr_en | input | 1 | Write strobe for the identifier register |
| reg_wr_data | input | 8 | Write data; bits 7:1 form the identifier |
| irq_en | input | 1 | Receive-available interrupt enable |
| irq_clr | input | 1 | Strobe that clears the interrupt |
| id_reg_o | output | 8 | Identifier in bits 7:1, mismatch flag in bit 0 |
| irq_o | output | 1 | Receive-available interrupt level |
| rx_data_o | output | 8 | Last accepted received byte |

## Verification
A wrong bit counter or a missed START shows up as a wrong `rx_data_o` value and a flag that contradicts the address sent. This appears within two clocks of the 8th SCL rise of the affected byte. If the matched/unmatched state is stuck, the first data byte after the address either raises an interrupt that should stay silent or raises none, and this is visible as soon as that byte ends. A flag or identifier that updates at the wrong moment is exposed by reading `id_reg_o` after register writes, after STOP and after a repeated START.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;
    localparam int ID_W       = 7;
    localparam int BYTE_W     = 8;
    localparam int CNT_W      = $clog2(BYTE_W + 1);
    localparam logic [BYTE_W-1:0] ID_REG_RST = 8'h42;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              is_addr;
    } rx_byte_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [ID_W-1:0]   id);
        return b[BYTE_W-1:1] == id;
    endfunction
endpackage

// File: rtl/bus_cond_detect.sv
module bus_cond_detect
    import addr_filt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        evt_o.start    = scl_q & scl_i & sda_q & ~sda_i;
        evt_o.stop     = scl_q & scl_i & ~sda_q & sda_i;
        evt_o.scl_rise = ~scl_q & scl_i;
    end

    // R8: a START is only recognised with SCL held high over two samples
    a_r8_start_scl_high: assert property (@(posedge clk) disable iff (rst)
        evt_o.start |-> scl_i && $past(scl_i));
endmodule

// File: rtl/byte_shifter.sv
module byte_shifter
    import addr_filt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sda_i,
    input  bus_evt_t evt_i,
    output logic     stb_o,
    output rx_byte_t rx_o
);
    logic              in_txn, first_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-2:0] shreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_txn  <= 1'b0;
            first_q <= 1'b0;
            cnt_q   <= '0;
            shreg_q <= '0;
            stb_o   <= 1'b0;
            rx_o    <= '0;
        end else begin
            stb_o <= 1'b0;
            if (evt_i.start) begin
                in_txn  <= 1'b1;
                first_q <= 1'b1;
                cnt_q   <= '0;
            end else if (evt_i.stop) begin
                in_txn <= 1'b0;
                cnt_q  <= '0;
            end else if (evt_i.scl_rise && in_txn) begin
                if (cnt_q == CNT_W'(BYTE_W)) begin
                    cnt_q   <= '0;
                    first_q <= 1'b0;
                end else begin
                    shreg_q <= {shreg_q[BYTE_W-3:0], sda_i};
                    cnt_q   <= cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                        stb_o        <= 1'b1;
                        rx_o.data    <= {shreg_q, sda_i};
                        rx_o.is_addr <= first_q;
                    end
                end
            end
        end
    end

    // R11: bit counter never passes the acknowledge slot
    a_r11_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(BYTE_W));
    // R8: any START re-arms address capture
    a_r8_rearm: assert property (@(posedge clk) disable iff (rst)
        evt_i.start |=> first_q && cnt_q == '0);
endmodule

// File: rtl/addr_match_ctl.sv
module addr_match_ctl
    import addr_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              stb_i,
    input  rx_byte_t          rx_i,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              irq_en_i,
    input  logic              irq_clr_i,
    output logic [ID_W-1:0]   id_o,
    output logic              mismatch_o,
    output logic              irq_o,
    output logic [BYTE_W-1:0] rx_data_o
);
    logic matched_q;
    logic hit;

    assign hit = addr_hit(rx_i.data, id_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            id_o       <= ID_REG_RST[BYTE_W-1:1];
            mismatch_o <= ID_REG_RST[0];
            matched_q  <= 1'b0;
            irq_o      <= 1'b0;
            rx_data_o  <= '0;
        end else begin
            if (wr_en_i) id_o <= wr_data_i[BYTE_W-1:1];
            if (start_i) matched_q <= 1'b0;
            if (irq_clr_i) irq_o <= 1'b0;
            if (stb_i) begin
                if (rx_i.is_addr) begin
                    mismatch_o <= ~hit;
                    matched_q  <= hit;
                    rx_data_o  <= rx_i.data;
                    if (irq_en_i) irq_o <= 1'b1;
                end else if (matched_q) begin
                    rx_data_o <= rx_i.data;
                    if (irq_en_i) irq_o <= 1'b1;
                end
            end
        end
    end

    // R2: identifier follows the written upper seven bits
    a_r2_id_write: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> id_o == $past(wr_data_i[BYTE_W-1:1]));
    // R5: the address byte always interrupts when enabled
    a_r5_addr_irq: assert property (@(posedge clk) disable iff (rst)
        stb_i && rx_i.is_addr && irq_en_i |=> irq_o);
    // R4: the flag only moves when an address byte completes
    a_r4_flag_hold: assert property (@(posedge clk) disable iff (rst)
        !(stb_i && rx_i.is_addr) |=> $stable(mismatch_o));
    // R7: the interrupt can only rise right after a received byte
    a_r7_irq_source: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(stb_i));
    // R10: a clear with no byte arriving drops the level
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        irq_clr_i && !stb_i |=> !irq_o);
endmodule

// File: rtl/i2c_addr_filter.sv
module i2c_addr_filter
    import addr_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              reg_wr_en,
    input  logic [BYTE_W-1:0] reg_wr_data,
    input  logic              irq_en,
    input  logic              irq_clr,
    output logic [BYTE_W-1:0] id_reg_o,
    output logic              irq_o,
    output logic [BYTE_W-1:0] rx_data_o
);
    bus_evt_t        evt;
    logic            stb;
    rx_byte_t        rxb;
    logic [ID_W-1:0] id;
    logic            mismatch;

    bus_cond_detect u_det (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .evt_o(evt)
    );

    byte_shifter u_shf (
        .clk(clk), .rst(rst), .sda_i(sda_i), .evt_i(evt),
        .stb_o(stb), .rx_o(rxb)
    );

    addr_match_ctl u_ctl (
        .clk(clk), .rst(rst), .start_i(evt.start), .stb_i(stb), .rx_i(rxb),
        .wr_en_i(reg_wr_en), .wr_data_i(reg_wr_data), .irq_en_i(irq_en),
        .irq_clr_i(irq_clr), .id_o(id), .mismatch_o(mismatch),
        .irq_o(irq_o), .rx_data_o(rx_data_o)
    );

    assign id_reg_o = {id, mismatch};
endmodule

// File: tb/sim_i2c_addr_filter.sv
module sim_i2c_addr_filter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1, sda = 1'b1;
    logic       wr_en = 1'b0, irq_en = 1'b1, irq_clr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] id_reg, rx_data;
    logic       irq;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    i2c_addr_filter u0 (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda),
        .reg_wr_en(wr_en), .reg_wr_data(wr_data), .irq_en(irq_en),
        .irq_clr(irq_clr), .id_reg_o(id_reg), .irq_o(irq),
        .rx_data_o(rx_data)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda = 1'b1; wclk(4);
        scl = 1'b1; wclk(4);
        sda = 1'b0; wclk(4);
        scl = 1'b0; wclk(4);
    endtask

    task automatic bus_stop;
        sda = 1'b0; wclk(4);
        scl = 1'b1; wclk(4);
        sda = 1'b1; wclk(4);
    endtask

    task automatic bus_byte(input logic [7:0] b);
        for (int i = 7; i >= -1; i--) begin
            sda = (i >= 0) ? b[i] : 1'b1;
            wclk(4);
            scl = 1'b1; wclk(4);
            scl = 1'b0;
        end
        wclk(4);
    endtask

    task automatic clear_irq;
        irq_clr = 1'b1; wclk(1);
        irq_clr = 1'b0; wclk(1);
    endtask

    task automatic write_id(input logic [7:0] v);
        wr_data = v; wr_en = 1'b1; wclk(1);
        wr_en = 1'b0; wclk(1);
    endtask

    task automatic t_reset;
        chk("R1 id reg", id_reg, 8'h42);
        chk("R1 irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_match;
        bus_start;
        bus_byte(8'h42);
        chk("R5 addr irq", {7'b0, irq}, 8'h01);
        chk("R4 flag match", id_reg, 8'h42);
        chk("R5 addr data", rx_data, 8'h42);
        clear_irq;
        chk("R10 cleared", {7'b0, irq}, 8'h00);
        wclk(10);
        chk("R10 stays low", {7'b0, irq}, 8'h00);
        bus_byte(8'hA5);
        chk("R6 data irq", {7'b0, irq}, 8'h01);
        chk("R6 data", rx_data, 8'hA5);
        clear_irq;
        bus_byte(8'h3C);
        chk("R6 second irq", {7'b0, irq}, 8'h01);
        chk("R11 no ack bit", rx_data, 8'h3C);
        clear_irq;
        bus_stop;
    endtask

    task automatic t_mismatch;
        bus_start;
        bus_byte(8'h50);
        chk("R5 addr irq on miss", {7'b0, irq}, 8'h01);
        chk("R4 flag miss", id_reg, 8'h43);
        clear_irq;
        bus_byte(8'h99);
        chk("R7 no irq", {7'b0, irq}, 8'h00);
        chk("R7 data kept", rx_data, 8'h50);
        bus_stop;
        chk("R4 flag held after stop", id_reg, 8'h43);
    endtask

    task automatic t_rw_bit;
        bus_start;
        bus_byte(8'h43);
        chk("R9 read bit ignored", id_reg, 8'h42);
        clear_irq;
        bus_stop;
    endtask

    task automatic t_write;
        write_id(8'h77);
        chk("R2 write bit0 ignored", id_reg, 8'h76);
        bus_start;
        bus_byte(8'h76);
        chk("R3 new id matches", id_reg, 8'h76);
        clear_irq;
        bus_stop;
        bus_start;
        bus_byte(8'h42);
        chk("R3 old id misses", id_reg, 8'h77);
        clear_irq;
        bus_stop;
        write_id(8'h42);
        chk("R2 restore keeps flag", id_reg, 8'h43);
    endtask

    task automatic t_rstart;
        bus_start;
        bus_byte(8'h10);
        chk("R8 first addr miss", id_reg, 8'h43);
        clear_irq;
        bus_start;
        bus_byte(8'h42);
        chk("R8 rearmed match", id_reg, 8'h42);
        chk("R8 addr irq", {7'b0, irq}, 8'h01);
        clear_irq;
        bus_byte(8'h5A);
        chk("R8 data after rstart", rx_data, 8'h5A);
        clear_irq;
        bus_stop;
    endtask

    task automatic t_disabled;
        irq_en = 1'b0;
        bus_start;
        bus_byte(8'h42);
        chk("R10 disabled addr", {7'b0, irq}, 8'h00);
        bus_byte(8'h11);
        chk("R10 disabled data", {7'b0, irq}, 8'h00);
        chk("R6 data while disabled", rx_data, 8'h11);
        bus_stop;
        irq_en = 1'b1;
    endtask

    initial begin
        wclk(3);
        rst = 1'b0;
        wclk(2);
        t_reset;
        t_match;
        t_mismatch;
        t_rw_bit;
        t_write;
        t_rstart;
        t_disabled;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule